// File: doc/BRIEF.md
# Double-Buffered Serial Byte Engine for a Single-Wire Bus

This block carries whole bytes between a host and a single-wire open-drain bus. The host drops a byte into a transmit holding register. When the shift stage is free the byte moves into it, so the host can queue a second byte while the first is still going out. The shift stage serialises the byte least significant bit first. For each bit it raises a slot request that carries the outgoing bit to a separate slot-timing unit. That unit answers with a one-cycle done pulse and the line value it sampled.

Each returned bit is combined with the bit that was sent: a 0 driven by the master can never read back as 1. Sampled bits fill a receive shift register. After the last bit of a byte they are copied into a receive holding register and the receive-full flag is raised. To read a slave byte, the host sends all ones. A slave that stays silent returns the sent byte unchanged. The host clears the receive-full flag with a read strobe. A byte that completes before that strobe overwrites the held byte.

Top module: `owire_byte_engine`

## Requirements
- R1: A cycle with `ld_stb` high stores `ld_data` in the holding register, and `tx_empty` reads 0 after that clock edge.
- R2: When the shift stage is empty and the holding register is full, the byte moves on the next clock edge. In that same edge `tx_empty` becomes 1 and `sh_empty` becomes 0, so after a write to an idle engine `tx_empty` returns to 1 one cycle later.
- R3: `sh_empty` is 0 and `slot_req` is 1 for as long as a byte is being shifted. A byte queued during that time stays in the holding register, with `tx_empty` at 0, until the shift stage frees.
- R4: Bits are offered on `slot_bit` least significant first. The engine advances to the next bit only on a cycle with `slot_done` high, and `slot_bit` holds steady until then.
- R5: Each received bit equals `slot_rx` AND the bit sent in that slot. Sending 0xFF returns the slave's byte, and a slave that answers all ones returns the byte that was sent.
- R6: On the `slot_done` of the eighth bit, `rx_data` takes the assembled byte (first bit in bit 0) and `rx_full` becomes 1 after that edge.
- R7: `rd_stb` clears `rx_full`. A byte completing in the same cycle keeps it set, and a byte that completes while `rx_full` is set replaces `rx_data`.
- R8: While `rst` is high, `tx_empty` and `sh_empty` are 1, `rx_full` is 0, `slot_req` is 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| ld_stb | input | 1 | Host write strobe for the transmit holding register |
| ld_data | input | W | Byte to transmit |
| rd_stb | input | 1 | Host read strobe; clears `rx_full` |
| slot_done | input | 1 | One-cycle pulse: the current bit slot has finished |
| slot_rx | input | 1 | Line value sampled in the finished slot |
| slot_req | output | 1 | A bit slot is requested |
| slot_bit | output | 1 | Bit to drive in the requested slot |
| rx_data | output | W | Receive holding register |
| tx_empty | output | 1 | Transmit holding register is empty |
| sh_empty | output | 1 | Transmit shift stage is empty |
| rx_full | output | 1 | Receive holding register holds an unread byte |

## Verification
The hardest case to reach from the ports is the receive overwrite. Two bytes must complete back to back with no read strobe between them, while a second byte sits queued behind a busy shift stage. The bench turns off its automatic reader, queues two bytes in a row against a slave that answers with distinct patterns, and then checks that only the second byte is held and that `rx_full` is still 1. A slave model with a variable response delay checks the order of the transmitted bits and how long each bit is held.

// File: rtl/owire_byte_engine.sv
module owire_byte_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_data,
  input  logic         rd_stb,
  input  logic         slot_done,
  input  logic         slot_rx,
  output logic         slot_req,
  output logic         slot_bit,
  output logic [W-1:0] rx_data,
  output logic         tx_empty,
  output logic         sh_empty,
  output logic         rx_full
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hold_q, tsh_q, rsh_q;
  logic          hold_v, busy;
  logic [CW-1:0] cnt;

  wire take   = !busy && hold_v;
  wire step   = busy && slot_done;
  wire rx_bit = slot_rx & tsh_q[0];
  wire done   = step && (cnt == LAST);
  wire [W-1:0] rsh_nx = {rx_bit, rsh_q[W-1:1]};

  assign slot_req = busy;
  assign slot_bit = tsh_q[0];
  assign tx_empty = !hold_v;
  assign sh_empty = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hold_v <= 1'b0;
    end else begin
      if (ld_stb) hold_q <= ld_data;
      if (ld_stb) hold_v <= 1'b1;
      else if (take) hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsh_q <= '0;
      rsh_q <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (take) begin
      tsh_q <= hold_q;
      busy  <= 1'b1;
      cnt   <= '0;
    end else if (step) begin
      tsh_q <= tsh_q >> 1;
      rsh_q <= rsh_nx;
      cnt   <= done ? '0 : cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
    end else if (done) begin
      rx_data <= rsh_nx;
      rx_full <= 1'b1;
    end else if (rd_stb) begin
      rx_full <= 1'b0;
    end
  end
endmodule

module owire_byte_engine_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_stb,
  input logic         rd_stb,
  input logic         slot_done,
  input logic         slot_req,
  input logic         slot_bit,
  input logic [W-1:0] rx_data,
  input logic         tx_empty,
  input logic         sh_empty,
  input logic         rx_full
);
  a_r1_load_fills: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> !tx_empty);
  a_r2_take: assert property (@(posedge clk) disable iff (rst)
    (sh_empty && !tx_empty) |=> !sh_empty);
  a_r2_move_frees: assert property (@(posedge clk) disable iff (rst)
    $fell(sh_empty) |-> (tx_empty || $past(ld_stb)));
  a_r3_req_busy: assert property (@(posedge clk) disable iff (rst)
    slot_req |-> !sh_empty);
  a_r4_bit_hold: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_done) |=> ($stable(slot_bit) && slot_req));
  a_r6_full_src: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(slot_done));
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_stb && !slot_done) |=> (rx_full && $stable(rx_data)));
  a_r8_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_empty && sh_empty && !rx_full && rx_data == '0));
endmodule

bind owire_byte_engine owire_byte_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_stb(ld_stb), .rd_stb(rd_stb),
  .slot_done(slot_done), .slot_req(slot_req), .slot_bit(slot_bit),
  .rx_data(rx_data), .tx_empty(tx_empty), .sh_empty(sh_empty),
  .rx_full(rx_full)
);

// File: tb/sim_owire_byte_engine.sv
module sim_owire_byte_engine;
  logic clk = 0, rst = 1, ld_stb = 0, rd_stb = 0, slot_done = 0, slot_rx = 0;
  logic [7:0] ld_data = 0;
  logic slot_req, slot_bit, tx_empty, sh_empty, rx_full;
  logic [7:0] rx_data;
  int total = 0, bad = 0, cyc = 0;
  bit auto_read = 1;
  logic [7:0] exp_tx[$], slv_q[$], exp_rx[$];

  owire_byte_engine #(.W(8)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] slv);
    while (!tx_empty) @(negedge clk);
    exp_tx.push_back(tx);
    slv_q.push_back(slv);
    exp_rx.push_back(tx & slv);
    ld_data = tx; ld_stb = 1;
    @(negedge clk);
    ld_stb = 0;
  endtask

  // slave model: checks R4 bit order and answers each slot
  initial begin
    logic [7:0] got, cur;
    int n = 0;
    forever begin
      @(negedge clk);
      if (slot_req && !rst) begin
        if (n == 0) cur = slv_q.pop_front();
        repeat (2 + (n % 3)) begin
          @(negedge clk);
          chk(slot_req && !sh_empty, "R3 req held", slot_req, 1);
        end
        got[n] = slot_bit;
        slot_rx = cur[n];
        slot_done = 1;
        @(negedge clk);
        slot_done = 0;
        n++;
        if (n == 8) begin
          logic [7:0] e;
          n = 0;
          e = exp_tx.pop_front();
          chk(got == e, "R4 lsb first", got, e);
        end
      end
    end
  end

  // monitor: scoreboard for received bytes, R5/R6/R7
  initial begin
    forever begin
      @(negedge clk);
      if (auto_read && rx_full && !rst) begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R5/R6 rx byte", rx_data, e);
        rd_stb = 1;
        @(negedge clk);
        rd_stb = 0;
        chk(!rx_full || slot_done, "R7 read clears", rx_full, 0);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_empty && sh_empty && !rx_full && !slot_req && rx_data == 0,
        "R8 reset", {tx_empty, sh_empty, rx_full, slot_req}, 4'b1100);
    rst = 0;
    @(negedge clk);
    // R1/R2 timing on idle engine
    exp_tx.push_back(8'hA5); slv_q.push_back(8'hFF); exp_rx.push_back(8'hA5);
    ld_data = 8'hA5; ld_stb = 1;
    @(negedge clk);
    ld_stb = 0;
    chk(!tx_empty && sh_empty, "R1 load", {tx_empty, sh_empty}, 2'b01);
    @(negedge clk);
    chk(tx_empty && !sh_empty && slot_req, "R2 move", {tx_empty, sh_empty}, 2'b10);
    chk(slot_bit == 1'b1, "R4 first bit", slot_bit, 1);
    // R3: queue behind busy shifter
    send(8'h3C, 8'hFF);
    repeat (4) @(negedge clk);
    chk(!tx_empty && !sh_empty, "R3 queued", {tx_empty, sh_empty}, 2'b00);
    // R5: reads and masking
    send(8'hFF, 8'h5A);
    send(8'hFF, 8'h00);
    send(8'h0F, 8'hF0);
    send(8'h81, 8'hFF);
    while (!(tx_empty && sh_empty && exp_rx.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
    // R7 overwrite: no reads between two bytes
    auto_read = 0;
    send(8'hFF, 8'h11);
    send(8'hFF, 8'h22);
    while (!(tx_empty && sh_empty)) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rx_full && rx_data == 8'h22, "R7 overwrite", rx_data, 8'h22);
    void'(exp_rx.pop_front()); void'(exp_rx.pop_front());
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    chk(!rx_full, "R7 clear", rx_full, 0);
    chk(rx_data == 8'h22, "R6 data kept", rx_data, 8'h22);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule